// File: doc/BRIEF.md
# Banked Working Register File

This block holds the 8-bit working registers of a small processor core: 256 byte addresses split into sixteen groups of sixteen registers. A four-bit group pointer, kept inside the block and loaded from the core, chooses which group the four-bit register index on each port refers to. Switching tasks means loading a new pointer value. No register is saved or restored, and the previous group's contents remain in place for the next switch back. Each port can also bypass the pointer and give a full 8-bit absolute address.

The block has two combinational read ports and one write port that takes effect at the clock edge. Each port selects either one byte or a 16-bit word. A word is an aligned pair: the even register is the high byte and the odd register is the low byte. Groups 0 to 13 are general working storage. Group 14 is the system page, which is stored internally but is reserved for system use. Group 15 holds no storage. Accesses to it are passed to a peripheral side bus through per-port strobes, and the read data comes back from that bus.

Top module: `bankRegFile`

## Requirements
- R1: After reset the group pointer is 0, the reserved-group flag is 0, and every internal register reads as 0.
- R2: In relative mode (absolute select low) the physical address is {group pointer, low four bits of the port address}; in absolute mode it is the full 8-bit port address.
- R3: Loading a new group pointer changes only which registers relative accesses reach; no register content changes, and returning to an earlier group shows its earlier values.
- R4: A byte write stores bits 7:0 of the write data at the address, ignoring bits 15:8; a byte read returns the register value in bits 7:0 with bits 15:8 zero.
- R5: A word access needs an even address: the write puts data bits 15:8 in the even register and bits 7:0 in the odd register, and the read returns {even, odd}.
- R6: A word access with an odd address raises that port's error output, writes nothing (no internal change, no peripheral write strobe), asserts no peripheral read strobe and returns read data 0.
- R7: An access whose address lies in group 15 (upper nibble 4'hF) asserts that port's peripheral strobe with the register index and word select on the side bus. A write there carries the write data and leaves internal storage unchanged. A read there returns the peripheral input (all 16 bits for a word, {8'h00, bits 7:0} for a byte).
- R8: Group 14 (addresses 8'hE0 to 8'hEF) is internal storage, reachable both by absolute address and through a pointer value of 14.
- R9: A read of an address that is being written in the same cycle returns the old value; the new value is visible after the clock edge.
- R10: A pointer load takes effect at the next edge for any value. The reserved-group flag is set when the loaded value is 14 or 15 and cleared when it is 0 to 13; it holds between loads.
- R11: The two read ports decode and return data independently of each other in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grpLoad | input | 1 | Load the group pointer from grpIn |
| grpIn | input | 4 | New group pointer value |
| grpPtr | output | 4 | Current group pointer |
| grpResvFlag | output | 1 | Pointer currently selects group 14 or 15 |
| rdAAbs | input | 1 | Port A absolute addressing |
| rdAWord | input | 1 | Port A word access |
| rdAAddr | input | 8 | Port A address (low nibble only in relative mode) |
| rdAData | output | 16 | Port A read data |
| rdAErr | output | 1 | Port A misaligned word |
| rdBAbs | input | 1 | Port B absolute addressing |
| rdBWord | input | 1 | Port B word access |
| rdBAddr | input | 8 | Port B address |
| rdBData | output | 16 | Port B read data |
| rdBErr | output | 1 | Port B misaligned word |
| wrEn | input | 1 | Write request |
| wrAbs | input | 1 | Write absolute addressing |
| wrWord | input | 1 | Write word access |
| wrAddr | input | 8 | Write address |
| wrData | input | 16 | Write data |
| wrErr | output | 1 | Write misaligned word (nothing written) |
| perRdAEn | output | 1 | Peripheral read strobe, port A |
| perRdAIdx | output | 4 | Peripheral register index, port A |
| perRdAWord | output | 1 | Peripheral word select, port A |
| perRdAData | input | 16 | Peripheral read data, port A |
| perRdBEn | output | 1 | Peripheral read strobe, port B |
| perRdBIdx | output | 4 | Peripheral register index, port B |
| perRdBWord | output | 1 | Peripheral word select, port B |
| perRdBData | input | 16 | Peripheral read data, port B |
| perWrEn | output | 1 | Peripheral write strobe |
| perWrIdx | output | 4 | Peripheral write register index |
| perWrWord | output | 1 | Peripheral write word select |
| perWrData | output | 16 | Peripheral write data |

## Verification
The assertions assume that every input is a known value at each sampled edge after reset. They also assume the core treats a raised error output as a dropped write, and does not expect the pointer to change except through grpLoad. The stimulus only changes inputs on the falling clock edge and holds them steady through the following rising edge. It keeps grpLoad low in every cycle where it depends on the current pointer. Misaligned words, group 14 and group 15 accesses, and read-during-write are each driven on purpose, one scenario at a time.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
  parameter int GRP_W  = 4;
  parameter int IDX_W  = 4;
  parameter int DATA_W = 8;
  localparam int ADDR_W = GRP_W + IDX_W;
  localparam int WORD_W = 2 * DATA_W;

  // Decoded view of one access port, produced by control, used by datapath.
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              word;
    logic              periph;
    logic              err;
  } accDec_t;

  // Internal array write strobe.
  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic              word;
  } wrStb_t;
endpackage

// File: rtl/bankrf_ctrl.sv
module bankrf_ctrl
  import bankrf_pkg::*;
#(
  parameter int NUM_RD = 2,
  parameter logic [GRP_W-1:0] SYS_GRP = 4'd14,
  parameter logic [GRP_W-1:0] PER_GRP = 4'd15
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          grpLoad,
  input  logic [GRP_W-1:0]              grpIn,
  input  logic [NUM_RD-1:0]             rdAbs,
  input  logic [NUM_RD-1:0]             rdWord,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr,
  input  logic                          wrEn,
  input  logic                          wrAbs,
  input  logic                          wrWord,
  input  logic [ADDR_W-1:0]             wrAddr,
  output logic [GRP_W-1:0]              grpPtr,
  output logic                          grpResvFlag,
  output accDec_t [NUM_RD-1:0]          rdDec,
  output wrStb_t                        wrStb,
  output logic                          wrErr,
  output logic                          perWrEn
);

  function automatic accDec_t decodeAcc(input logic [GRP_W-1:0] ptr, input logic abs,
                                        input logic word, input logic [ADDR_W-1:0] addr);
    accDec_t d;
    d.addr   = abs ? addr : {ptr, addr[IDX_W-1:0]};
    d.word   = word;
    d.err    = word && d.addr[0];
    d.periph = (d.addr[ADDR_W-1 -: GRP_W] == PER_GRP) && !d.err;
    return d;
  endfunction

  // Group pointer register and reserved-selection flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpPtr      <= '0;
      grpResvFlag <= 1'b0;
    end else if (grpLoad) begin
      grpPtr      <= grpIn;
      grpResvFlag <= (grpIn == SYS_GRP) || (grpIn == PER_GRP);
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : gRdDec
    assign rdDec[g] = decodeAcc(grpPtr, rdAbs[g], rdWord[g], rdAddr[g]);
  end

  accDec_t wrDec;
  assign wrDec    = decodeAcc(grpPtr, wrAbs, wrWord, wrAddr);
  assign wrStb.en   = wrEn && !wrDec.err && !wrDec.periph;
  assign wrStb.addr = wrDec.addr;
  assign wrStb.word = wrDec.word;
  assign wrErr      = wrEn && wrDec.err;
  assign perWrEn    = wrEn && wrDec.periph;

  p_grp_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    grpLoad |=> grpPtr == $past(grpIn));
  p_grp_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !grpLoad |=> $stable(grpPtr) && $stable(grpResvFlag));
  p_resv_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    grpLoad |=> grpResvFlag == ($past(grpIn) >= SYS_GRP));
  p_no_write_on_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> !wrStb.en && !perWrEn);
  p_periph_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    perWrEn |-> !wrStb.en);
endmodule

// File: rtl/bankrf_dp.sv
module bankrf_dp
  import bankrf_pkg::*;
#(
  parameter int NUM_RD = 2,
  parameter int STORE_GROUPS = 15
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wrStb_t                        wrStb,
  input  logic [WORD_W-1:0]             wrData,
  input  accDec_t [NUM_RD-1:0]          rdDec,
  input  logic [NUM_RD-1:0][WORD_W-1:0] perRdData,
  output logic [NUM_RD-1:0][WORD_W-1:0] rdData
);
  localparam int STORE_DEPTH = STORE_GROUPS * (1 << IDX_W);

  logic [DATA_W-1:0] mem [STORE_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STORE_DEPTH; i++) mem[i] <= '0;
    end else if (wrStb.en) begin
      if (wrStb.word) begin
        mem[{wrStb.addr[ADDR_W-1:1], 1'b0}] <= wrData[WORD_W-1:DATA_W];
        mem[{wrStb.addr[ADDR_W-1:1], 1'b1}] <= wrData[DATA_W-1:0];
      end else begin
        mem[wrStb.addr] <= wrData[DATA_W-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : gRdMux
    always_comb begin
      rdData[g] = '0;
      if (rdDec[g].err) begin
        rdData[g] = '0;
      end else if (rdDec[g].periph) begin
        rdData[g] = rdDec[g].word ? perRdData[g]
                                  : {{DATA_W{1'b0}}, perRdData[g][DATA_W-1:0]};
      end else if (rdDec[g].word) begin
        rdData[g] = {mem[{rdDec[g].addr[ADDR_W-1:1], 1'b0}],
                     mem[{rdDec[g].addr[ADDR_W-1:1], 1'b1}]};
      end else begin
        rdData[g] = {{DATA_W{1'b0}}, mem[rdDec[g].addr]};
      end
    end
  end

  p_word_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.en && wrStb.word |=>
      mem[{$past(wrStb.addr[ADDR_W-1:1]), 1'b0}] == $past(wrData[WORD_W-1:DATA_W]));
  p_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.en && wrStb.word |-> !wrStb.addr[0]);
  p_storage_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.en |-> int'(wrStb.addr) < STORE_DEPTH);
endmodule

// File: rtl/bankRegFile.sv
module bankRegFile
  import bankrf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               grpLoad,
  input  logic [GRP_W-1:0]   grpIn,
  output logic [GRP_W-1:0]   grpPtr,
  output logic               grpResvFlag,
  input  logic               rdAAbs,
  input  logic               rdAWord,
  input  logic [ADDR_W-1:0]  rdAAddr,
  output logic [WORD_W-1:0]  rdAData,
  output logic               rdAErr,
  input  logic               rdBAbs,
  input  logic               rdBWord,
  input  logic [ADDR_W-1:0]  rdBAddr,
  output logic [WORD_W-1:0]  rdBData,
  output logic               rdBErr,
  input  logic               wrEn,
  input  logic               wrAbs,
  input  logic               wrWord,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0]  wrData,
  output logic               wrErr,
  output logic               perRdAEn,
  output logic [IDX_W-1:0]   perRdAIdx,
  output logic               perRdAWord,
  input  logic [WORD_W-1:0]  perRdAData,
  output logic               perRdBEn,
  output logic [IDX_W-1:0]   perRdBIdx,
  output logic               perRdBWord,
  input  logic [WORD_W-1:0]  perRdBData,
  output logic               perWrEn,
  output logic [IDX_W-1:0]   perWrIdx,
  output logic               perWrWord,
  output logic [WORD_W-1:0]  perWrData
);
  localparam int NUM_RD = 2;

  accDec_t [NUM_RD-1:0]          rdDec;
  wrStb_t                        wrStb;
  logic [NUM_RD-1:0][WORD_W-1:0] rdData;

  bankrf_ctrl #(.NUM_RD(NUM_RD)) uCtrl (
    .clk(clk), .rstN(rstN), .grpLoad(grpLoad), .grpIn(grpIn),
    .rdAbs({rdBAbs, rdAAbs}), .rdWord({rdBWord, rdAWord}),
    .rdAddr({rdBAddr, rdAAddr}),
    .wrEn(wrEn), .wrAbs(wrAbs), .wrWord(wrWord), .wrAddr(wrAddr),
    .grpPtr(grpPtr), .grpResvFlag(grpResvFlag), .rdDec(rdDec),
    .wrStb(wrStb), .wrErr(wrErr), .perWrEn(perWrEn)
  );

  bankrf_dp #(.NUM_RD(NUM_RD)) uDp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .rdDec(rdDec),
    .perRdData({perRdBData, perRdAData}), .rdData(rdData)
  );

  assign rdAData    = rdData[0];
  assign rdBData    = rdData[1];
  assign rdAErr     = rdDec[0].err;
  assign rdBErr     = rdDec[1].err;
  assign perRdAEn   = rdDec[0].periph;
  assign perRdAIdx  = rdDec[0].addr[IDX_W-1:0];
  assign perRdAWord = rdDec[0].word;
  assign perRdBEn   = rdDec[1].periph;
  assign perRdBIdx  = rdDec[1].addr[IDX_W-1:0];
  assign perRdBWord = rdDec[1].word;
  assign perWrIdx   = wrStb.addr[IDX_W-1:0];
  assign perWrWord  = wrStb.word;
  assign perWrData  = wrData;
endmodule

// File: tb/tb_bankRegFile.sv
module tb_bankRegFile;
  logic clk = 0, rstN = 0;
  logic grpLoad = 0; logic [3:0] grpIn = 0;
  logic [3:0] grpPtr; logic grpResvFlag;
  logic rdAAbs = 0, rdAWord = 0; logic [7:0] rdAAddr = 0; logic [15:0] rdAData; logic rdAErr;
  logic rdBAbs = 0, rdBWord = 0; logic [7:0] rdBAddr = 0; logic [15:0] rdBData; logic rdBErr;
  logic wrEn = 0, wrAbs = 0, wrWord = 0; logic [7:0] wrAddr = 0; logic [15:0] wrData = 0;
  logic wrErr;
  logic perRdAEn, perRdAWord, perRdBEn, perRdBWord, perWrEn, perWrWord;
  logic [3:0] perRdAIdx, perRdBIdx, perWrIdx;
  logic [15:0] perRdAData = 0, perRdBData = 0, perWrData;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  bankRegFile dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setA(input logic abs, input logic [7:0] a, input logic w);
    rdAAbs = abs; rdAAddr = a; rdAWord = w; #1;
  endtask
  task automatic setB(input logic abs, input logic [7:0] a, input logic w);
    rdBAbs = abs; rdBAddr = a; rdBWord = w; #1;
  endtask

  task automatic doWrite(input logic abs, input logic [7:0] a, input logic w, input logic [15:0] d);
    @(negedge clk); wrEn = 1; wrAbs = abs; wrAddr = a; wrWord = w; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic loadPtr(input logic [3:0] g);
    @(negedge clk); grpLoad = 1; grpIn = g;
    @(negedge clk); grpLoad = 0; #1;
  endtask

  task automatic t_reset;
    check("R1 ptr", grpPtr, 0);
    check("R1 flag", grpResvFlag, 0);
    setA(1, 8'h00, 1); check("R1 word 00", rdAData, 0);
    setB(1, 8'hEF, 0); check("R1 byte EF", rdBData, 0);
  endtask

  task automatic t_byte;
    doWrite(0, 8'h03, 0, 16'hFF5A);
    setA(0, 8'h73, 0); check("R4 byte read, upper ignored", rdAData, 16'h005A);
    setA(1, 8'h03, 0); check("R2 relative ptr0 = abs 03", rdAData, 16'h005A);
  endtask

  task automatic t_word;
    doWrite(0, 8'h04, 1, 16'hBEEF);
    setA(0, 8'h04, 1); setB(0, 8'h04, 0);
    check("R5 word read", rdAData, 16'hBEEF);
    check("R5 R11 even=high", rdBData, 16'h00BE);
    setB(0, 8'h05, 0); check("R5 R11 odd=low", rdBData, 16'h00EF);
    check("R11 port A unaffected", rdAData, 16'hBEEF);
  endtask

  task automatic t_odd;
    @(negedge clk); wrEn = 1; wrAbs = 0; wrAddr = 8'h05; wrWord = 1; wrData = 16'h1234; #1;
    check("R6 wrErr", wrErr, 1);
    check("R6 no periph strobe", perWrEn, 0);
    @(negedge clk); wrEn = 0;
    setB(0, 8'h05, 0); check("R6 odd reg kept", rdBData, 16'h00EF);
    setB(0, 8'h06, 0); check("R6 next reg kept", rdBData, 16'h0000);
    setA(0, 8'h05, 1);
    check("R6 rdAErr", rdAErr, 1);
    check("R6 err data 0", rdAData, 0);
    setA(1, 8'hF3, 1);
    check("R6 odd periph no strobe", perRdAEn, 0);
  endtask

  task automatic t_ctx;
    loadPtr(4'd2);
    check("R10 ptr loaded", grpPtr, 2);
    check("R10 flag clear", grpResvFlag, 0);
    doWrite(0, 8'h03, 0, 16'h0077);
    setA(1, 8'h23, 0); check("R2 abs 23", rdAData, 16'h0077);
    setA(1, 8'h03, 0); check("R3 group0 intact", rdAData, 16'h005A);
    loadPtr(4'd0);
    setA(0, 8'h03, 0); check("R3 back to group0", rdAData, 16'h005A);
  endtask

  task automatic t_sys;
    loadPtr(4'd14);
    check("R10 ptr 14 accepted", grpPtr, 14);
    check("R10 flag 14", grpResvFlag, 1);
    doWrite(0, 8'h01, 0, 16'h0099);
    setA(1, 8'hE1, 0); check("R8 system page stored", rdAData, 16'h0099);
    loadPtr(4'd3);
    check("R10 flag cleared", grpResvFlag, 0);
  endtask

  task automatic t_periph;
    perRdAData = 16'hCAFE; perRdBData = 16'h1357;
    setA(1, 8'hF2, 1);
    check("R7 strobe", perRdAEn, 1);
    check("R7 idx", perRdAIdx, 2);
    check("R7 word sel", perRdAWord, 1);
    check("R7 word data", rdAData, 16'hCAFE);
    setA(1, 8'hF2, 0); check("R7 byte data", rdAData, 16'h00FE);
    setA(1, 8'h12, 1); check("R7 no strobe outside", perRdAEn, 0);
    @(negedge clk); wrEn = 1; wrAbs = 1; wrAddr = 8'hF4; wrWord = 1; wrData = 16'h2468; #1;
    check("R7 wr strobe", perWrEn, 1);
    check("R7 wr idx", perWrIdx, 4);
    check("R7 wr data", perWrData, 16'h2468);
    @(negedge clk); wrEn = 0;
    setA(1, 8'h04, 1); check("R7 internal untouched", rdAData, 16'hBEEF);
    loadPtr(4'd15);
    check("R10 flag 15", grpResvFlag, 1);
    setB(0, 8'h07, 0);
    check("R7 relative periph", perRdBEn, 1);
    check("R7 relative idx", perRdBIdx, 7);
    check("R7 B data", rdBData, 16'h0057);
    loadPtr(4'd0);
  endtask

  task automatic t_rdw;
    @(negedge clk); wrEn = 1; wrAbs = 0; wrAddr = 8'h03; wrWord = 0; wrData = 16'h0011;
    setA(0, 8'h03, 0); check("R9 old value", rdAData, 16'h005A);
    @(negedge clk); wrEn = 0; #1;
    check("R9 new after edge", rdAData, 16'h0011);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1; #1;
        t_reset(); t_byte(); t_word(); t_odd(); t_ctx(); t_sys(); t_periph(); t_rdw();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule